// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned W-bit integer by another over several clock cycles. A start pulse captures the operands while the block is idle. The block then resolves one quotient bit per cycle using the non-restoring method. An internal accumulator one bit wider than the operands keeps a true sign bit. That sign bit decides whether the next step adds the divisor back or subtracts it again, so no step inside the loop ever undoes an earlier one.

After the last quotient bit, a single extra cycle adds the divisor once more if the partial remainder is negative. The result then appears with a one-cycle done pulse. Quotient and remainder stay on the outputs until the next accepted start. A zero divisor is not trapped. The loop simply runs as usual, and a flag marks the result as not mathematically meaningful.

Top module: `nr_divider`

## Requirements
- R1: While reset is held and on the first cycle after it is released, busy, done, div_by_zero, quotient and remainder are all zero.
- R2: A start seen while busy is low captures dividend and divisor, and busy is high on the next cycle.
- R3: Busy stays high for exactly W+1 cycles after an accepted start: W cycles of iteration and one correction cycle. Done is high for exactly one cycle, the cycle on which busy has just fallen.
- R4: With a nonzero divisor, quotient equals the integer part of dividend divided by divisor when done is high.
- R5: With a nonzero divisor, remainder equals dividend modulo divisor when done is high, and is therefore smaller than the divisor.
- R6: A start raised while busy is high is ignored. The running division keeps its operands and its timing, and it produces exactly one done.
- R7: A zero divisor sets div_by_zero, and the result on done is a quotient of all ones (2^W-1) and a remainder equal to the dividend. A nonzero divisor leaves div_by_zero at 0.
- R8: After done, quotient, remainder and div_by_zero hold their values while the block is idle, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; taken only when busy is low |
| dividend | input | W | Unsigned dividend, sampled on an accepted start |
| divisor | input | W | Unsigned divisor, sampled on an accepted start |
| busy | output | 1 | High while a division is iterating or correcting |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | W | Quotient, valid from done until the next accepted start |
| remainder | output | W | Remainder, valid from done until the next accepted start |
| div_by_zero | output | 1 | Set when the captured divisor is zero |

## Verification
Some properties are checked on every cycle. The fixed busy length of W+1 cycles, done as a single pulse that coincides with busy falling, and outputs held while idle are all checked this way. So is the arithmetic identity: quotient times divisor plus remainder equals dividend, with the remainder below the divisor, for the operands captured at the accepted start. Other behaviour can only be shown by the bench's scenarios. These are the exact quotient and remainder values against the reference operators (exhaustively at W=6 and with random and edge operands at W=16), the defined all-ones result for a zero divisor, and the fact that a start raised in the middle of a division changes nothing.

// File: rtl/nr_divider.sv
module nr_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_t;

  state_t        st;
  logic [W:0]    acc;
  logic [W-1:0]  qr;
  logic [W-1:0]  dv;
  logic [CW-1:0] cnt;
  logic          done_q;
  logic          dbz_q;

  logic [W:0] dv_ext, acc_sh, acc_nx, acc_fix;
  logic       accept;

  assign accept  = start && (st == S_IDLE);
  assign dv_ext  = {1'b0, dv};
  assign acc_sh  = {acc[W-1:0], qr[W-1]};
  assign acc_nx  = acc[W] ? (acc_sh + dv_ext) : (acc_sh + (~dv_ext) + 1'b1);
  assign acc_fix = acc[W] ? (acc + dv_ext) : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      acc    <= '0;
      qr     <= '0;
      dv     <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
      dbz_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          acc   <= '0;
          qr    <= dividend;
          dv    <= divisor;
          dbz_q <= (divisor == '0);
          cnt   <= CW'(W);
          st    <= S_RUN;
        end
        S_RUN: begin
          acc <= acc_nx;
          qr  <= {qr[W-2:0], ~acc_nx[W]};
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_FIX;
        end
        S_FIX: begin
          acc    <= acc_fix;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign quotient    = qr;
  assign remainder   = acc[W-1:0];
  assign div_by_zero = dbz_q;
endmodule

// File: rtl/nr_divider_chk.sv
module nr_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_by_zero
);
  localparam int BW = $clog2(W + 3);

  logic [W-1:0]   cap_a, cap_d;
  logic [BW-1:0]  busy_len;
  logic [2*W-1:0] recon;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a    <= '0;
      cap_d    <= '0;
      busy_len <= '0;
    end else begin
      if (start && !busy) begin
        cap_a <= dividend;
        cap_d <= divisor;
      end
      busy_len <= busy ? busy_len + 1'b1 : '0;
    end
  end

  assign recon = {{W{1'b0}}, quotient} * {{W{1'b0}}, cap_d} + {{W{1'b0}}, remainder};

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_len == BW'(W + 1));

  p_done_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_identity_r4: assert property (@(posedge clk) disable iff (rst)
    done && cap_d != '0 |-> recon == {{W{1'b0}}, cap_a});

  p_rem_below_r5: assert property (@(posedge clk) disable iff (rst)
    done && cap_d != '0 |-> remainder < cap_d);

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> div_by_zero == (cap_d == '0));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy && !done |-> $stable(quotient) && $stable(remainder) && $stable(div_by_zero));
endmodule

bind nr_divider nr_divider_chk #(.W(W)) u_chk (.*);

// File: tb/nr_divider_tb.sv
module nr_divider_tb;
  localparam int WB = 16;
  localparam int WS = 6;

  typedef struct packed { logic [WB-1:0] q; logic [WB-1:0] r; logic z; } exp_b_t;
  typedef struct packed { logic [WS-1:0] q; logic [WS-1:0] r; logic z; } exp_s_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic          st_b = 1'b0, st_s = 1'b0;
  logic [WB-1:0] a_b = '0, d_b = '0;
  logic [WS-1:0] a_s = '0, d_s = '0;
  logic          busy_b, done_b, z_b, busy_s, done_s, z_s;
  logic [WB-1:0] q_b, r_b;
  logic [WS-1:0] q_s, r_s;

  exp_b_t qb[$];
  exp_s_t qs[$];

  nr_divider #(.W(WB)) u_dut (
    .clk(clk), .rst(rst), .start(st_b), .dividend(a_b), .divisor(d_b),
    .busy(busy_b), .done(done_b), .quotient(q_b), .remainder(r_b), .div_by_zero(z_b));

  nr_divider #(.W(WS)) u_dut_small (
    .clk(clk), .rst(rst), .start(st_s), .dividend(a_s), .divisor(d_s),
    .busy(busy_s), .done(done_s), .quotient(q_s), .remainder(r_s), .div_by_zero(z_s));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitors: pop expected results as done pulses appear
  always @(posedge clk) begin
    #1;
    if (!rst && done_b) begin
      exp_b_t e;
      check(qb.size() != 0, "R6 unexpected done (W=16)", qb.size(), 1);
      if (qb.size() != 0) begin
        e = qb.pop_front();
        check(q_b == e.q, "R4/R7 quotient (W=16)", q_b, e.q);
        check(r_b == e.r, "R5/R7 remainder (W=16)", r_b, e.r);
        check(z_b == e.z, "R7 div_by_zero (W=16)", z_b, e.z);
      end
    end
    if (!rst && done_s) begin
      exp_s_t e;
      check(qs.size() != 0, "R6 unexpected done (W=6)", qs.size(), 1);
      if (qs.size() != 0) begin
        e = qs.pop_front();
        check(q_s == e.q, "R4/R7 quotient (W=6)", q_s, e.q);
        check(r_s == e.r, "R5/R7 remainder (W=6)", r_s, e.r);
        check(z_s == e.z, "R7 div_by_zero (W=6)", z_s, e.z);
      end
    end
  end

  task automatic run_b(input logic [WB-1:0] a, input logic [WB-1:0] d, input bit intrude, input bit hold);
    exp_b_t e;
    int n;
    e.z = (d == '0);
    e.q = e.z ? '1 : a / d;
    e.r = e.z ? a : a % d;
    qb.push_back(e);
    @(negedge clk);
    a_b = a; d_b = d; st_b = 1'b1;
    @(negedge clk);
    st_b = 1'b0;
    check(busy_b, "R2 busy after start (W=16)", busy_b, 1);
    n = 1;
    while (!done_b && n < 100) begin
      @(negedge clk);
      n++;
      if (intrude && n == 3) begin
        a_b = ~a; d_b = 16'd3; st_b = 1'b1;   // R6: start while busy
      end else st_b = 1'b0;
    end
    st_b = 1'b0;
    check(n == WB + 2, "R3 latency (W=16)", n, WB + 2);
    check(!busy_b, "R3 busy low with done (W=16)", busy_b, 0);
    if (hold) begin
      repeat (3) @(negedge clk);
      check(!done_b, "R3 done single pulse (W=16)", done_b, 0);
      check(q_b == e.q && r_b == e.r && z_b == e.z, "R8 outputs held (W=16)", q_b, e.q);
    end
  endtask

  task automatic run_s(input logic [WS-1:0] a, input logic [WS-1:0] d);
    exp_s_t e;
    int n;
    e.z = (d == '0);
    e.q = e.z ? '1 : a / d;
    e.r = e.z ? a : a % d;
    qs.push_back(e);
    @(negedge clk);
    a_s = a; d_s = d; st_s = 1'b1;
    @(negedge clk);
    st_s = 1'b0;
    n = 1;
    while (!done_s && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == WS + 2, "R3 latency (W=6)", n, WS + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_b && !done_b && !z_b && q_b == '0 && r_b == '0, "R1 reset state (W=16)", q_b, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_b && !done_b && !z_b && q_b == '0 && r_b == '0, "R1 after release (W=16)", r_b, 0);
    check(!busy_s && !done_s && !z_s, "R1 after release (W=6)", busy_s, 0);

    for (int a = 0; a < (1 << WS); a++)
      for (int d = 0; d < (1 << WS); d++)
        run_s(WS'(a), WS'(d));

    run_b(16'hFFFF, 16'h0001, 1'b0, 1'b1);
    run_b(16'hFFFF, 16'hFFFF, 1'b0, 1'b1);
    run_b(16'h0005, 16'hFFFF, 1'b0, 1'b0);
    run_b(16'h8000, 16'h8001, 1'b0, 1'b0);
    run_b(16'h1234, 16'h0000, 1'b0, 1'b1);   // R7
    run_b(16'h0000, 16'h0007, 1'b0, 1'b0);
    run_b(16'hBEEF, 16'h0013, 1'b1, 1'b1);   // R6
    run_b(16'h7FFF, 16'h0002, 1'b1, 1'b0);   // R6
    for (int i = 0; i < 1500; i++) begin
      logic [WB-1:0] ra, rd;
      ra = WB'($urandom);
      rd = WB'($urandom);
      if (i % 3 == 0) rd = rd >> (i % 16);
      run_b(ra, rd, 1'b0, 1'b0);
    end

    repeat (4) @(negedge clk);
    check(qb.size() == 0 && qs.size() == 0, "R6 all results delivered", qb.size() + qs.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule